// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends bytes, or 9-bit words, over a two-wire synchronous link. The link's master supplies the shift clock on `ext_clk`. The block never generates or drives a clock. The external clock is brought into the system clock domain through a two-stage synchronizer. Every falling edge of that clock, after optional polarity inversion, moves the data pin to the next bit. Bits go out least-significant first, so the master can sample each one on the rising edge.

Software writes words into a single holding register over a valid/ready interface. `wr_ready` is high exactly while the holding register is empty. A word is accepted only on a cycle where `wr_valid` and `wr_ready` are both high. A word offered while `wr_ready` is low is not taken, and it has no effect.

When the shift register is idle, an accepted word moves into it on the following cycle. Another word can then be queued behind it. The holding-empty flag rises only at the moment a word leaves the holding register, and the interrupt request is that flag gated by an enable bit. The request is a pure combinational gate, so it needs no system clock activity to reach the pin.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, and with `tx_ie` low, `hold_empty`=1, `wr_ready`=1, `shift_empty`=1, `data_out`=1 and `irq`=0.
- R2: The transmitter runs only while all of the following hold: `port_en`=1, `sync_mode`=1, `clk_master`=0, `rx_single_en`=0, `rx_cont_en`=0 and `tx_en`=1. In any other case, `shift_empty` is 1 and `data_out` is 1 from the next cycle on, and the held word is not loaded.
- R3: `wr_ready` equals `hold_empty`. A cycle with `wr_valid`=1 and `wr_ready`=1 captures `wr_data`, `ninth_bit` and `nine_bit_en`. `wr_valid` while `wr_ready`=0 changes nothing.
- R4: Take an enabled transmitter with `shift_empty`=1. A word accepted at edge N makes `hold_empty` 0 after edge N. After edge N+1, `hold_empty` is 1 again, `shift_empty` is 0, and `data_out` shows bit 0 of the word.
- R5: A word accepted while another is shifting stays held, with `hold_empty`=0, until the falling edge that ends the current word's last bit. On that edge the held word loads and `hold_empty` becomes 1.
- R6: Bits leave least-significant first. `data_out` advances one bit on each falling edge of the effective clock. The change appears at the third system clock edge after the edge of `ext_clk` (two synchronizer stages plus the output register).
- R7: If `nine_bit_en` was 1 when the word was written, the `ninth_bit` value captured at that write is sent after the 8 data bits, for 9 bit periods in total. Otherwise 8 bits are sent.
- R8: `shift_empty` is 0 from the load until the falling edge that ends the final bit. If no word is waiting at that edge, `data_out` returns to 1.
- R9: `irq` = `hold_empty` AND `tx_ie`, combinationally.
- R10: The effective clock is `ext_clk` XOR `clk_invert`. With `clk_invert`=1, bits advance on rising edges of `ext_clk`.
- R11: Clearing `tx_en` in the middle of a word drops that word: `shift_empty`=1 and `data_out`=1 after the next edge. A word waiting in the holding register is kept, and it is sent from its bit 0 once `tx_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Shift clock from the link master |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock-source select; 0 selects slave operation |
| rx_single_en | input | 1 | Single receive enable; must be 0 for transmit |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 for transmit |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | 9-bit word mode, sampled at write |
| ninth_bit | input | 1 | Ninth data bit, sampled at write |
| tx_ie | input | 1 | Interrupt enable for holding-empty |
| clk_invert | input | 1 | Inverts the external clock polarity |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Holding register can accept a word |
| data_out | output | 1 | Serial data pin, idle high |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the falling edge that ends a word's last bit while a second word is waiting. On that edge the shifter must finish, reload and raise `hold_empty`, all in one cycle. To get there, the stimulus queues a second word the moment the first leaves the holding register, and it offers a third word while the register is full.

An abort in the middle of a word, with a word still pending, is reached by dropping `tx_en` between external clock edges. Enable gating is reached by raising a receive enable while a word is held. A behavioural queue model in the bench predicts every output on every cycle.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/sstx_clk_sync.sv
module sstx_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic invert,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= ext_clk ^ invert;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign fall = prev & ~chain[STAGES-1];

  // R6
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nine_en,
  input  logic              ninth,
  input  logic              load,
  output logic              wr_ready,
  output logic              full,
  output logic [DATA_W:0]   word,
  output logic              word_nine
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      word      <= '0;
      word_nine <= 1'b0;
    end else if (load) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full      <= 1'b1;
      word      <= {ninth, wr_data};
      word_nine <= nine_en;
    end
  end

  assign wr_ready = !full;

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !load |=> full && $stable(word) && $stable(word_nine));

  // R5
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(load));
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            fall,
  input  logic            hold_full,
  input  logic [DATA_W:0] hold_word,
  input  logic            hold_nine,
  output logic            load,
  output logic            data_out,
  output logic            shift_empty
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  sh_state_e        state;
  logic [DATA_W:0]  sh;
  logic [CNT_W-1:0] left;
  logic             last;

  assign last = (left == '0);
  assign load = active && hold_full && ((state == SH_IDLE) || (fall && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      sh       <= '0;
      left     <= '0;
      data_out <= 1'b1;
    end else if (!active) begin
      state    <= SH_IDLE;
      left     <= '0;
      data_out <= 1'b1;
    end else if (load) begin
      state    <= SH_BUSY;
      sh       <= hold_word;
      data_out <= hold_word[0];
      left     <= hold_nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    end else if (fall && state == SH_BUSY) begin
      if (last) begin
        state    <= SH_IDLE;
        data_out <= 1'b1;
      end else begin
        sh       <= sh >> 1;
        data_out <= sh[1];
        left     <= left - 1'b1;
      end
    end
  end

  assign shift_empty = (state == SH_IDLE);

  // R11
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> shift_empty && data_out);

  // R8
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !shift_empty);

  // R6
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !fall && !load |=> $stable(data_out));

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> data_out);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_master,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              ninth_bit,
  input  logic              tx_ie,
  input  logic              clk_invert,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              data_out,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic            active;
  logic            fall;
  logic            load;
  logic            hold_full;
  logic [DATA_W:0] hold_word;
  logic            hold_nine;

  assign active = port_en && sync_mode && !clk_master &&
                  !rx_single_en && !rx_cont_en && tx_en;

  sstx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .invert  (clk_invert),
    .fall    (fall)
  );

  sstx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .nine_en   (nine_bit_en),
    .ninth     (ninth_bit),
    .load      (load),
    .wr_ready  (wr_ready),
    .full      (hold_full),
    .word      (hold_word),
    .word_nine (hold_nine)
  );

  sstx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .fall        (fall),
    .hold_full   (hold_full),
    .hold_word   (hold_word),
    .hold_nine   (hold_nine),
    .load        (load),
    .data_out    (data_out),
    .shift_empty (shift_empty)
  );

  assign hold_empty = !hold_full;
  assign irq        = hold_empty && tx_ie;

  // R2
  no_load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !load);

  // R4
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && shift_empty && !wr_ready |=> wr_ready && !shift_empty);
endmodule

// File: tb/sim_sync_slave_tx.sv
`timescale 1ns/1ps
module sim_sync_slave_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b0;
  logic rx_single_en = 1'b0, rx_cont_en = 1'b0, tx_en = 1'b1;
  logic nine_bit_en = 1'b0, ninth_bit = 1'b0, tx_ie = 1'b0, clk_invert = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, data_out, hold_empty, shift_empty, irq;

  int n_cmp = 0, n_bad = 0;
  int div = 0;
  bit ext_run = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  sync_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .port_en(port_en),
    .sync_mode(sync_mode), .clk_master(clk_master), .rx_single_en(rx_single_en),
    .rx_cont_en(rx_cont_en), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
    .ninth_bit(ninth_bit), .tx_ie(tx_ie), .clk_invert(clk_invert),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .data_out(data_out), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .irq(irq)
  );

  // Reference model: queue of bits still to send, plus holding state
  bit       mq[$];
  bit       m_full = 0;
  bit [8:0] m_hw = '0;
  bit       m_hn = 0;
  bit       m_out = 1;
  bit       m_h0 = 0, m_h1 = 0, m_h2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_full = 0; m_hw = '0; m_hn = 0; m_out = 1;
      m_h0 = 0; m_h1 = 0; m_h2 = 0;
    end else begin
      bit fall, act, ld;
      fall = (m_h2 == 1 && m_h1 == 0);
      act  = port_en && sync_mode && !clk_master && !rx_single_en &&
             !rx_cont_en && tx_en;
      ld   = act && m_full && (mq.size() == 0 || (fall && mq.size() == 1));
      if (!act) begin
        mq.delete(); m_out = 1;
      end else if (ld) begin
        mq.delete();
        for (int i = 0; i < (m_hn ? 9 : 8); i++) mq.push_back(m_hw[i]);
        m_out = mq[0];
      end else if (fall && mq.size() > 0) begin
        void'(mq.pop_front());
        m_out = (mq.size() > 0) ? mq[0] : 1'b1;
      end
      if (ld) m_full = 0;
      else if (wr_valid && !m_full) begin
        m_full = 1; m_hw = {ninth_bit, wr_data}; m_hn = nine_bit_en;
      end
      m_h2 = m_h1; m_h1 = m_h0; m_h0 = ext_clk ^ clk_invert;
    end
  end

  task automatic chk(string sig, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", phase, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("data_out", data_out, m_out);
    chk("hold_empty", hold_empty, !m_full);
    chk("wr_ready", wr_ready, !m_full);
    chk("shift_empty", shift_empty, mq.size() == 0);
    chk("irq", irq, !m_full && tx_ie);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      if (rst_n) compare();
      if (ext_run) begin
        div++;
        if (div == 4) begin div = 0; ext_clk = ~ext_clk; end
      end
    end
  endtask

  task automatic put(logic [7:0] d);
    while (m_full) tick(1);
    wr_valid = 1'b1; wr_data = d;
    tick(1);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk("hold_empty", hold_empty, 1'b1);
    chk("wr_ready", wr_ready, 1'b1);
    chk("shift_empty", shift_empty, 1'b1);
    chk("data_out", data_out, 1'b1);
    chk("irq", irq, 1'b0);
    tx_ie = 1'b1;
    ext_run = 1;
    tick(20);

    phase = "R4_R6";
    put(8'hA5);
    tick(100);

    phase = "R5_R3";
    put(8'h3C);
    put(8'hC3);
    wr_valid = 1'b1; wr_data = 8'hFF;   // offered while full: ignored
    tick(3);
    wr_valid = 1'b0;
    tick(200);

    phase = "R7";
    nine_bit_en = 1'b1; ninth_bit = 1'b1;
    put(8'h0F);
    ninth_bit = 1'b0;
    put(8'h81);
    nine_bit_en = 1'b0;
    tick(200);

    phase = "R9";
    tx_ie = 1'b0;
    put(8'h5A);
    tick(100);
    tx_ie = 1'b1;
    tick(4);

    phase = "R10";
    ext_run = 0;
    tick(8);
    clk_invert = 1'b1;
    tick(8);
    ext_run = 1;
    put(8'h96);
    tick(100);
    ext_run = 0;
    tick(8);
    clk_invert = 1'b0;
    tick(8);
    ext_run = 1;

    phase = "R11";
    put(8'h55);
    put(8'hAA);
    tick(20);
    tx_en = 1'b0;
    tick(30);
    tx_en = 1'b1;
    tick(200);

    phase = "R2";
    rx_cont_en = 1'b1;
    put(8'h33);
    tick(60);
    rx_cont_en = 1'b0;
    tick(40);
    clk_master = 1'b1;
    tick(20);
    clk_master = 1'b0;
    rx_single_en = 1'b1;
    tick(20);
    rx_single_en = 1'b0;
    tick(200);

    phase = "R8";
    put(8'h01);
    tick(150);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s actual=hung expected=complete", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule